// File: doc/BRIEF.md
# TDM Substitution Slot Receiver

This block sits behind the deserializer of a time-division-multiplexed serial port. It takes one 16-bit word per slot and, in intercept mode, moves replacement audio for two streams into their own small stereo buffers. The streams are playback and capture. A downstream mixer drains each buffer through its own read port. Slot 0 of every frame carries a command word. In that word, one valid-in bit covers playback and one covers capture. A stream takes data only when its valid-in bit is set, its intercept enable is on, and it raised its request flag at the start of the frame. That start-of-frame sample means a frame carries data only when the block asked for it one frame earlier.

Each buffer holds four stereo pairs. The request flag of a stream tells the sender whether that buffer has room. Two modes change how capture data is taken. In modem mode, the right capture slot belongs to the modem, so one mono sample is copied into both channels. In rate-lock mode, capture runs at the playback rate, and the playback valid-in bit and the playback request decide whether capture data is taken.

Top module: `tdm_sub_rx`

## Requirements
- R1: `ply_req` is high exactly when `ply_icpt_en` is high and the playback buffer holds fewer than four pairs. `cap_req` follows the same rule with `cap_icpt_en` and the capture buffer. Both flags are combinational from the current enable and the current fill level.
- R2: A `frame_sync` pulse samples the request flags of both streams. The command word arrives as the slot 0 word. Its bit 1 is the playback valid-in bit and its bit 0 is the capture valid-in bit. A playback pair is written only when bit 1 is set, `ply_icpt_en` is high, and `ply_req` was high at the most recent `frame_sync`.
- R3: For an accepted playback frame, slot 4 is the right sample and slot 5 is the left sample. The pair goes into the buffer on the slot 5 word.
- R4: With `modem_mode` and `rate_lock` both low, a capture pair is written only when command bit 0 is set, `cap_icpt_en` is high, and `cap_req` was high at the last `frame_sync`. Slot 2 is the right sample and slot 3 is the left sample, and the pair is written on the slot 3 word.
- R5: With `modem_mode` high, slot 2 is ignored for capture. The slot 3 word is written as both the left and the right capture sample.
- R6: With `rate_lock` high, capture is gated by command bit 1, by the playback request sampled at the last `frame_sync`, and by both intercept enables. Command bit 0 then has no effect.
- R7: When the valid-in bit that governs a stream is clear for a frame, that stream's slot data is dropped, and its buffer stays empty or keeps its contents.
- R8: Each buffer returns pairs in the order they were written. A write that finds the buffer full is dropped, and it sets that stream's sticky overflow flag (`ply_ovf` or `cap_ovf`). A read in the same cycle as a write to a full buffer frees the room, so that write is accepted.
- R9: While `rst` is high, both buffers are emptied, both overflow flags are cleared, and the stored command bits and request history are cleared. Until a `frame_sync` occurs after reset, no pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | One-cycle pulse before slot 0 of each frame |
| slot_vld | input | 1 | Strobe: a slot word is present |
| slot_idx | input | 4 | Index of the present slot |
| slot_data | input | 16 | Slot word |
| ply_icpt_en | input | 1 | Playback intercept enable |
| cap_icpt_en | input | 1 | Capture intercept enable |
| modem_mode | input | 1 | Mono capture from slot 3 only |
| rate_lock | input | 1 | Capture gated by playback valid and request |
| ply_rd | input | 1 | Pop the head playback pair |
| ply_rd_vld | output | 1 | Playback buffer not empty |
| ply_rd_l | output | 16 | Head playback left sample |
| ply_rd_r | output | 16 | Head playback right sample |
| cap_rd | input | 1 | Pop the head capture pair |
| cap_rd_vld | output | 1 | Capture buffer not empty |
| cap_rd_l | output | 16 | Head capture left sample |
| cap_rd_r | output | 16 | Head capture right sample |
| ply_req | output | 1 | Playback request flag |
| cap_req | output | 1 | Capture request flag |
| ply_ovf | output | 1 | Sticky playback overflow |
| cap_ovf | output | 1 | Sticky capture overflow |

## Verification
The mixer's pop and the slot-3 capture write can land in the same cycle while the capture buffer is full. The bench fills the capture buffer in rate-lock mode and raises `cap_rd` on the slot 3 word of the next frame. It then drains the buffer and expects the three older pairs followed by the new pair. An earlier frame sent to the full buffer is expected to leave no trace and to set `cap_ovf`.

// File: rtl/tdm_sub_pkg.sv
package tdm_sub_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int SLOT_W    = 4;
    localparam int PAIR_DEPTH = 4;

    localparam int SLOT_CMD   = 0;
    localparam int SLOT_CAP_R = 2;
    localparam int SLOT_CAP_L = 3;
    localparam int SLOT_PLY_R = 4;
    localparam int SLOT_PLY_L = 5;

    localparam int CMD_CAP_BIT = 0;
    localparam int CMD_PLY_BIT = 1;
endpackage

// File: rtl/tdm_sub_fifo.sv
module tdm_sub_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wl_i,
    input  logic [W-1:0] wr_r_i,
    input  logic         rd_i,
    output logic         vld_o,
    output logic [W-1:0] rl_o,
    output logic [W-1:0] rr_o,
    output logic         full_o,
    output logic         ovf_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][2*W-1:0] mem;
        logic [PW-1:0]             wp;
        logic [PW-1:0]             rp;
        logic [CW-1:0]             cnt;
        logic                      ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic pop, push_ok;

    always_comb begin
        st_d    = st_q;
        pop     = rd_i && (st_q.cnt != '0);
        push_ok = wr_i && ((st_q.cnt != CW'(DEPTH)) || pop);
        if (push_ok) begin
            st_d.mem[st_q.wp] = {wl_i, wr_r_i};
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (pop) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        if (push_ok && !pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !push_ok) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_i && !push_ok) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = (st_q.cnt != '0);
    assign full_o = (st_q.cnt == CW'(DEPTH));
    assign ovf_o  = st_q.ovf;
    assign rl_o   = st_q.mem[st_q.rp][2*W-1:W];
    assign rr_o   = st_q.mem[st_q.rp][W-1:0];

    // R8: a write into a full buffer without a read leaves it full and flags overflow
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_i && full_o && !rd_i) |=> (full_o && ovf_o));

    // R8: overflow is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R8: occupancy never exceeds the depth
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(DEPTH));

    // R9: reset leaves the buffer empty and overflow clear
    p_reset_empty_r9: assert property (@(posedge clk)
        $past(rst) |-> (!vld_o && !ovf_o));
endmodule

// File: rtl/tdm_sub_slot_dec.sv
module tdm_sub_slot_dec
    import tdm_sub_pkg::*;
#(
    parameter int W  = SAMPLE_W,
    parameter int SW = SLOT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_sync,
    input  logic          slot_vld,
    input  logic [SW-1:0] slot_idx,
    input  logic [W-1:0]  slot_data,
    input  logic          ply_en,
    input  logic          cap_en,
    input  logic          modem_mode,
    input  logic          rate_lock,
    input  logic          ply_req,
    input  logic          cap_req,
    output logic          ply_wr,
    output logic [W-1:0]  ply_wl,
    output logic [W-1:0]  ply_wrr,
    output logic          cap_wr,
    output logic [W-1:0]  cap_wl,
    output logic [W-1:0]  cap_wrr
);
    typedef struct packed {
        logic         cmd_ply;
        logic         cmd_cap;
        logic         preq_ply;
        logic         preq_cap;
        logic [W-1:0] ply_r;
        logic [W-1:0] cap_r;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    word_in;
    logic    ply_gate, cap_gate;

    always_comb begin
        st_d    = st_q;
        word_in = slot_vld && !frame_sync;
        if (frame_sync) begin
            st_d.preq_ply = ply_req;
            st_d.preq_cap = cap_req;
            st_d.cmd_ply  = 1'b0;
            st_d.cmd_cap  = 1'b0;
            st_d.ply_r    = '0;
            st_d.cap_r    = '0;
        end else if (word_in) begin
            if (slot_idx == SW'(SLOT_CMD)) begin
                st_d.cmd_ply = slot_data[CMD_PLY_BIT];
                st_d.cmd_cap = slot_data[CMD_CAP_BIT];
            end
            if (slot_idx == SW'(SLOT_PLY_R)) begin
                st_d.ply_r = slot_data;
            end
            if (slot_idx == SW'(SLOT_CAP_R) && !modem_mode) begin
                st_d.cap_r = slot_data;
            end
        end

        ply_gate = st_q.cmd_ply && st_q.preq_ply && ply_en;
        cap_gate = rate_lock ? (ply_gate && cap_en)
                             : (st_q.cmd_cap && st_q.preq_cap && cap_en);

        ply_wr  = word_in && (slot_idx == SW'(SLOT_PLY_L)) && ply_gate;
        ply_wl  = slot_data;
        ply_wrr = st_q.ply_r;
        cap_wr  = word_in && (slot_idx == SW'(SLOT_CAP_L)) && cap_gate;
        cap_wl  = slot_data;
        cap_wrr = modem_mode ? slot_data : st_q.cap_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: in modem mode a capture write carries the same sample on both channels
    p_modem_mono_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_wr && modem_mode) |-> (cap_wl == cap_wrr));

    // R2: no playback write happens while playback intercept is off
    p_ply_gated_r2: assert property (@(posedge clk) disable iff (rst)
        !ply_en |-> !ply_wr);
endmodule

// File: rtl/tdm_sub_rx.sv
module tdm_sub_rx
    import tdm_sub_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_sync,
    input  logic                slot_vld,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [SAMPLE_W-1:0] slot_data,
    input  logic                ply_icpt_en,
    input  logic                cap_icpt_en,
    input  logic                modem_mode,
    input  logic                rate_lock,
    input  logic                ply_rd,
    output logic                ply_rd_vld,
    output logic [SAMPLE_W-1:0] ply_rd_l,
    output logic [SAMPLE_W-1:0] ply_rd_r,
    input  logic                cap_rd,
    output logic                cap_rd_vld,
    output logic [SAMPLE_W-1:0] cap_rd_l,
    output logic [SAMPLE_W-1:0] cap_rd_r,
    output logic                ply_req,
    output logic                cap_req,
    output logic                ply_ovf,
    output logic                cap_ovf
);
    logic                ply_full, cap_full;
    logic                ply_wr, cap_wr;
    logic [SAMPLE_W-1:0] ply_wl, ply_wrr, cap_wl, cap_wrr;

    assign ply_req = ply_icpt_en && !ply_full;
    assign cap_req = cap_icpt_en && !cap_full;

    tdm_sub_slot_dec #(.W(SAMPLE_W), .SW(SLOT_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .slot_vld   (slot_vld),
        .slot_idx   (slot_idx),
        .slot_data  (slot_data),
        .ply_en     (ply_icpt_en),
        .cap_en     (cap_icpt_en),
        .modem_mode (modem_mode),
        .rate_lock  (rate_lock),
        .ply_req    (ply_req),
        .cap_req    (cap_req),
        .ply_wr     (ply_wr),
        .ply_wl     (ply_wl),
        .ply_wrr    (ply_wrr),
        .cap_wr     (cap_wr),
        .cap_wl     (cap_wl),
        .cap_wrr    (cap_wrr)
    );

    tdm_sub_fifo #(.W(SAMPLE_W), .DEPTH(PAIR_DEPTH)) u_ply_buf (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (ply_wr),
        .wl_i   (ply_wl),
        .wr_r_i (ply_wrr),
        .rd_i   (ply_rd),
        .vld_o  (ply_rd_vld),
        .rl_o   (ply_rd_l),
        .rr_o   (ply_rd_r),
        .full_o (ply_full),
        .ovf_o  (ply_ovf)
    );

    tdm_sub_fifo #(.W(SAMPLE_W), .DEPTH(PAIR_DEPTH)) u_cap_buf (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (cap_wr),
        .wl_i   (cap_wl),
        .wr_r_i (cap_wrr),
        .rd_i   (cap_rd),
        .vld_o  (cap_rd_vld),
        .rl_o   (cap_rd_l),
        .rr_o   (cap_rd_r),
        .full_o (cap_full),
        .ovf_o  (cap_ovf)
    );

    // R1: a request is never raised with the stream's intercept off
    p_req_needs_en_r1: assert property (@(posedge clk) disable iff (rst)
        (ply_req |-> ply_icpt_en) and (cap_req |-> cap_icpt_en));
endmodule

// File: tb/tdm_sub_rx_bench.sv
module tdm_sub_rx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_sync = 1'b0, slot_vld = 1'b0;
    logic [3:0]  slot_idx = '0;
    logic [15:0] slot_data = '0;
    logic        ply_icpt_en = 1'b0, cap_icpt_en = 1'b0;
    logic        modem_mode = 1'b0, rate_lock = 1'b0;
    logic        ply_rd = 1'b0, cap_rd = 1'b0;
    logic        ply_rd_vld, cap_rd_vld, ply_req, cap_req, ply_ovf, cap_ovf;
    logic [15:0] ply_rd_l, ply_rd_r, cap_rd_l, cap_rd_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tdm_sub_rx u_tdm_sub_rx (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .slot_vld(slot_vld),
        .slot_idx(slot_idx), .slot_data(slot_data),
        .ply_icpt_en(ply_icpt_en), .cap_icpt_en(cap_icpt_en),
        .modem_mode(modem_mode), .rate_lock(rate_lock),
        .ply_rd(ply_rd), .ply_rd_vld(ply_rd_vld), .ply_rd_l(ply_rd_l), .ply_rd_r(ply_rd_r),
        .cap_rd(cap_rd), .cap_rd_vld(cap_rd_vld), .cap_rd_l(cap_rd_l), .cap_rd_r(cap_rd_r),
        .ply_req(ply_req), .cap_req(cap_req), .ply_ovf(ply_ovf), .cap_ovf(cap_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // frame: sync pulse, then slots 0..5; optional late playback enable, optional capture pop on slot 3
    task automatic send_frame(input logic [15:0] cmd, input logic [15:0] s2, input logic [15:0] s3,
                              input logic [15:0] s4, input logic [15:0] s5,
                              input bit late_ply_en, input bit pop_cap_s3);
        logic [15:0] words [6];
        words = '{cmd, 16'h0, s2, s3, s4, s5};
        @(negedge clk);
        if (late_ply_en) ply_icpt_en = 1'b0;
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        if (late_ply_en) ply_icpt_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            slot_vld  = 1'b1;
            slot_idx  = 4'(i);
            slot_data = words[i];
            cap_rd    = pop_cap_s3 && (i == 3);
            @(negedge clk);
        end
        slot_vld = 1'b0;
        cap_rd   = 1'b0;
    endtask

    task automatic pop_ply(input string tag, input logic [15:0] l, input logic [15:0] r);
        chk({tag, " ply vld"}, 32'(ply_rd_vld), 32'd1);
        chk({tag, " ply pair"}, {ply_rd_l, ply_rd_r}, {l, r});
        ply_rd = 1'b1;
        @(negedge clk);
        ply_rd = 1'b0;
    endtask

    task automatic pop_cap(input string tag, input logic [15:0] l, input logic [15:0] r);
        chk({tag, " cap vld"}, 32'(cap_rd_vld), 32'd1);
        chk({tag, " cap pair"}, {cap_rd_l, cap_rd_r}, {l, r});
        cap_rd = 1'b1;
        @(negedge clk);
        cap_rd = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 ply empty", 32'(ply_rd_vld), 32'd0);
        chk("R9 cap empty", 32'(cap_rd_vld), 32'd0);
        chk("R9 ovf clear", {ply_ovf, cap_ovf}, 32'd0);
        chk("R1 req off when disabled", {ply_req, cap_req}, 32'd0);
        ply_icpt_en = 1'b1;
        cap_icpt_en = 1'b1;
        #0.5;
        chk("R1 req on when enabled and empty", {ply_req, cap_req}, 32'b11);
    endtask

    task automatic t_history();
        send_frame(16'h0002, 16'h0, 16'h0, 16'h1111, 16'h2222, 1'b1, 1'b0);
        chk("R2 no request at frame start drops pair", 32'(ply_rd_vld), 32'd0);
    endtask

    task automatic t_play();
        send_frame(16'h0002, 16'h0, 16'h0, 16'hA004, 16'hB005, 1'b0, 1'b0);
        chk("R7 capture dropped with bit 0 clear", 32'(cap_rd_vld), 32'd0);
        pop_ply("R3", 16'hB005, 16'hA004);
        send_frame(16'h0000, 16'h0, 16'h0, 16'hA104, 16'hB105, 1'b0, 1'b0);
        chk("R7 playback dropped with bit 1 clear", 32'(ply_rd_vld), 32'd0);
    endtask

    task automatic t_capture();
        send_frame(16'h0001, 16'hC002, 16'hD003, 16'h0, 16'h0, 1'b0, 1'b0);
        chk("R7 playback dropped under capture-only cmd", 32'(ply_rd_vld), 32'd0);
        pop_cap("R4", 16'hD003, 16'hC002);
        modem_mode = 1'b1;
        send_frame(16'h0001, 16'hEEEE, 16'h5353, 16'h0, 16'h0, 1'b0, 1'b0);
        pop_cap("R5", 16'h5353, 16'h5353);
        modem_mode = 1'b0;
    endtask

    task automatic t_rate_lock();
        rate_lock = 1'b1;
        send_frame(16'h0001, 16'h0102, 16'h0103, 16'h0, 16'h0, 1'b0, 1'b0);
        chk("R6 capture bit ignored under rate lock", 32'(cap_rd_vld), 32'd0);
        send_frame(16'h0002, 16'h0202, 16'h0203, 16'h0204, 16'h0205, 1'b0, 1'b0);
        pop_cap("R6", 16'h0203, 16'h0202);
        pop_ply("R6 ply", 16'h0205, 16'h0204);
    endtask

    task automatic t_fill();
        for (int k = 0; k < 4; k++) begin
            send_frame(16'h0002, 16'(16'h100 + k), 16'(16'h200 + k), 16'h0, 16'h0, 1'b0, 1'b0);
            pop_ply("R8 fill ply", 16'h0, 16'h0);
        end
        chk("R1 cap req low when full", 32'(cap_req), 32'd0);
        chk("R1 ply req high after drain", 32'(ply_req), 32'd1);
        chk("R8 no overflow yet", 32'(cap_ovf), 32'd0);
        send_frame(16'h0002, 16'h0999, 16'h0998, 16'h0, 16'h0, 1'b0, 1'b0);
        chk("R8 overflow sticky set", 32'(cap_ovf), 32'd1);
        pop_ply("R8 ply", 16'h0, 16'h0);
        send_frame(16'h0002, 16'h0555, 16'h0666, 16'h0, 16'h0, 1'b0, 1'b1);
        pop_ply("R8 ply", 16'h0, 16'h0);
        for (int k = 1; k < 4; k++) pop_cap("R8 order", 16'(16'h200 + k), 16'(16'h100 + k));
        pop_cap("R8 read+write at full", 16'h0666, 16'h0555);
        chk("R8 drained", 32'(cap_rd_vld), 32'd0);
        chk("R8 overflow stays", 32'(cap_ovf), 32'd1);
        rate_lock = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        t_reset();
        t_history();
        t_play();
        t_capture();
        t_rate_lock();
        t_fill();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule